// File: doc/BRIEF.md
# Quarter-Rate XGA Raster Timing Generator

This block produces the raster timing for a 1024x768, 60 Hz display while clocking pixels at a quarter of the standard 65 MHz dot rate, that is 16.25 MHz. A horizontal counter spans 336 clocks per line: 256 visible columns and 80 clocks of blanking. A vertical counter spans all 806 lines of the full-rate mode. Because the two low bits of the line number are discarded, each visible coordinate line appears on four consecutive scan lines. The resulting grid is 256 by 192.

Every timing signal is decoded straight from the raw counts. These signals are horizontal and vertical visibility, the two active-low sync pulses, an end-of-line strobe and a final-line flag. All of them are then captured in one output register stage, so they share one cycle of latency. The block also outputs the 8-bit x and y coordinates for a downstream frame source.

A small built-in pattern lights the red channel as the NOR of one column bit and one line bit, which gives a field of red blocks. Green and blue are held at zero. All colour outputs are forced to black outside the visible area.

Top module: `qxga_timing_gen`

## Requirements
- R1: A synchronous reset clears both counters. While reset is high, every output takes its idle value at the next edge: hsyncN and vsyncN at 1, and activeVideo, lineEnd, lastRow, pixX, pixY, red, green and blue at 0. The first output sample after release describes column 0 of line 0.
- R2: The column count runs from 0 to H_VIS+H_FP+H_SYNC+H_BP-1, which is 335 by default, and then returns to 0. lineEnd is 1 exactly for the final column of each line.
- R3: The line count advances by one only on a final-column cycle. After the final column of line V_VIS+V_FP+V_SYNC+V_BP-1 (805 by default) it returns to 0.
- R4: hsyncN is 0 exactly for columns H_VIS+H_FP through H_VIS+H_FP+H_SYNC-1, which is 262 to 295 by default, and is 1 on all other columns.
- R5: vsyncN is 0 exactly on lines V_VIS+V_FP through V_VIS+V_FP+V_SYNC-1, which is 771 to 776 by default, and is 1 on all other lines.
- R6: lastRow is 1 exactly on the final line, which is 805 by default.
- R7: activeVideo is 1 exactly when the column is below H_VIS (256) and the line is below V_VIS (768).
- R8: pixX equals column bits [7:0], and pixY equals line bits [9:2].
- R9: red is all ones when activeVideo is 1 and both column bit PAT_COL_BIT and line bit PAT_ROW_BIT are 0. Otherwise red is 0. Green and blue are always 0, so all colours are 0 whenever activeVideo is 0.
- R10: Every output reflects the counter state of the previous clock. All outputs therefore share one register of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock (16.25 MHz nominal) |
| rst | input | 1 | Synchronous reset, active high |
| hsyncN | output | 1 | Horizontal sync, active low |
| vsyncN | output | 1 | Vertical sync, active low |
| activeVideo | output | 1 | High inside the visible area |
| lineEnd | output | 1 | High on the final column of a line |
| lastRow | output | 1 | High throughout the final line of a frame |
| pixX | output | COORD_W (8) | Horizontal coordinate |
| pixY | output | COORD_W (8) | Vertical coordinate, line number divided by four |
| red | output | COLOR_W (4) | Red channel, carrying the block pattern |
| green | output | COLOR_W (4) | Green channel, always black |
| blue | output | COLOR_W (4) | Blue channel, always black |

## Verification
The bench keeps the counter widths, the coordinate slicing and the divide-by-four line mapping at their defaults. It shrinks the timing to a 24-clock line (16 visible, porches 2 and 3, sync 3) and a 13-line frame (8 visible, porches 1 and 2, sync 2). It sets the pattern bits to column bit 2 and line bit 1. With these values, several complete frames fit in under a thousand cycles. This brings within reach every sync edge, every wrap of both counters and the frame-restart condition, as well as a reset taken in the middle of a frame, all compared against a behavioural model on every clock.

// File: rtl/qxga_timing_pkg.sv
package qxga_timing_pkg;

  // Strobes passed from the counter control to the decode datapath.
  typedef struct packed {
    logic lineEnd;   // final column of the current line
    logic lastRow;   // final line of the current frame
  } strobe_t;

endpackage

// File: rtl/qxga_counter_ctrl.sv
module qxga_counter_ctrl
  import qxga_timing_pkg::*;
#(
  parameter int COL_W   = 9,
  parameter int ROW_W   = 10,
  parameter int H_TOTAL = 336,
  parameter int V_TOTAL = 806
) (
  input  logic             clk,
  input  logic             rst,
  output logic [COL_W-1:0] colCount,
  output logic [ROW_W-1:0] rowCount,
  output strobe_t          strobes
);

  localparam logic [COL_W-1:0] COL_LAST = COL_W'(H_TOTAL - 1);
  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(V_TOTAL - 1);
  localparam logic [COL_W-1:0] COL_ONE  = COL_W'(1);
  localparam logic [ROW_W-1:0] ROW_ONE  = ROW_W'(1);

  always_comb begin
    strobes.lineEnd = (colCount == COL_LAST);
    strobes.lastRow = (rowCount == ROW_LAST);
  end

  // Column counter: wraps at the end of each line.
  always_ff @(posedge clk) begin
    if (rst) begin
      colCount <= '0;
    end else if (strobes.lineEnd) begin
      colCount <= '0;
    end else begin
      colCount <= colCount + COL_ONE;
    end
  end

  // Line counter: steps on each line end and restarts after the final line.
  always_ff @(posedge clk) begin
    if (rst) begin
      rowCount <= '0;
    end else if (strobes.lineEnd) begin
      if (strobes.lastRow) begin
        rowCount <= '0;
      end else begin
        rowCount <= rowCount + ROW_ONE;
      end
    end
  end

  assert_col_wrap_R2 : assert property (@(posedge clk) disable iff (rst)
    (colCount == COL_LAST) |=> (colCount == '0));

  assert_col_step_R2 : assert property (@(posedge clk) disable iff (rst)
    (colCount != COL_LAST) |=> (colCount == $past(colCount) + COL_ONE));

  assert_row_hold_R3 : assert property (@(posedge clk) disable iff (rst)
    (colCount != COL_LAST) |=> $stable(rowCount));

  assert_row_wrap_R3 : assert property (@(posedge clk) disable iff (rst)
    (colCount == COL_LAST && rowCount == ROW_LAST) |=> (rowCount == '0));

endmodule

// File: rtl/qxga_decode_dp.sv
module qxga_decode_dp
  import qxga_timing_pkg::*;
#(
  parameter int COL_W       = 9,
  parameter int ROW_W       = 10,
  parameter int COORD_W     = 8,
  parameter int ROW_SHIFT   = 2,
  parameter int COLOR_W     = 4,
  parameter int H_VIS       = 256,
  parameter int H_FP        = 6,
  parameter int H_SYNC      = 34,
  parameter int V_VIS       = 768,
  parameter int V_FP        = 3,
  parameter int V_SYNC      = 6,
  parameter int PAT_COL_BIT = 5,
  parameter int PAT_ROW_BIT = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [COL_W-1:0]   colCount,
  input  logic [ROW_W-1:0]   rowCount,
  input  strobe_t            strobes,
  output logic               hsyncN,
  output logic               vsyncN,
  output logic               activeVideo,
  output logic               lineEnd,
  output logic               lastRow,
  output logic [COORD_W-1:0] pixX,
  output logic [COORD_W-1:0] pixY,
  output logic [COLOR_W-1:0] red,
  output logic [COLOR_W-1:0] green,
  output logic [COLOR_W-1:0] blue
);

  localparam logic [COL_W-1:0] HS_FIRST = COL_W'(H_VIS + H_FP);
  localparam logic [COL_W-1:0] HS_AFTER = COL_W'(H_VIS + H_FP + H_SYNC);
  localparam logic [ROW_W-1:0] VS_FIRST = ROW_W'(V_VIS + V_FP);
  localparam logic [ROW_W-1:0] VS_AFTER = ROW_W'(V_VIS + V_FP + V_SYNC);
  localparam logic [COL_W-1:0] COL_VIS  = COL_W'(H_VIS);
  localparam logic [ROW_W-1:0] ROW_VIS  = ROW_W'(V_VIS);

  logic visX, visY, visBoth, hsActive, vsActive, patternOn;
  logic [COLOR_W-1:0] redNext;

  always_comb begin
    visX      = (colCount < COL_VIS);
    visY      = (rowCount < ROW_VIS);
    visBoth   = visX && visY;
    hsActive  = (colCount >= HS_FIRST) && (colCount < HS_AFTER);
    vsActive  = (rowCount >= VS_FIRST) && (rowCount < VS_AFTER);
    patternOn = ~(colCount[PAT_COL_BIT] | rowCount[PAT_ROW_BIT]);
  end

  // Colour width is a parameter: replicate the pattern bit across each lane.
  for (genvar b = 0; b < COLOR_W; b++) begin : gen_red_lane
    assign redNext[b] = patternOn && visBoth;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hsyncN      <= 1'b1;
      vsyncN      <= 1'b1;
      activeVideo <= 1'b0;
      lineEnd     <= 1'b0;
      lastRow     <= 1'b0;
      pixX        <= '0;
      pixY        <= '0;
      red         <= '0;
      green       <= '0;
      blue        <= '0;
    end else begin
      hsyncN      <= ~hsActive;
      vsyncN      <= ~vsActive;
      activeVideo <= visBoth;
      lineEnd     <= strobes.lineEnd;
      lastRow     <= strobes.lastRow;
      pixX        <= colCount[COORD_W-1:0];
      pixY        <= rowCount[ROW_SHIFT +: COORD_W];
      red         <= redNext;
      green       <= '0;
      blue        <= '0;
    end
  end

  assert_blank_black_R9 : assert property (@(posedge clk) disable iff (rst)
    !activeVideo |-> (red == '0 && green == '0 && blue == '0));

  assert_sync_blank_R7 : assert property (@(posedge clk) disable iff (rst)
    activeVideo |-> (hsyncN && vsyncN));

  assert_hsync_start_R4 : assert property (@(posedge clk) disable iff (rst)
    $fell(hsyncN) |-> (pixX == COORD_W'(H_VIS + H_FP)));

  assert_lastrow_entry_R6 : assert property (@(posedge clk) disable iff (rst)
    $rose(lastRow) |-> $past(lineEnd));

endmodule

// File: rtl/qxga_timing_gen.sv
module qxga_timing_gen
  import qxga_timing_pkg::*;
#(
  parameter int COL_W       = 9,
  parameter int ROW_W       = 10,
  parameter int COORD_W     = 8,
  parameter int ROW_SHIFT   = 2,
  parameter int COLOR_W     = 4,
  parameter int H_VIS       = 256,
  parameter int H_FP        = 6,
  parameter int H_SYNC      = 34,
  parameter int H_BP        = 40,
  parameter int V_VIS       = 768,
  parameter int V_FP        = 3,
  parameter int V_SYNC      = 6,
  parameter int V_BP        = 29,
  parameter int PAT_COL_BIT = 5,
  parameter int PAT_ROW_BIT = 7
) (
  input  logic               clk,
  input  logic               rst,
  output logic               hsyncN,
  output logic               vsyncN,
  output logic               activeVideo,
  output logic               lineEnd,
  output logic               lastRow,
  output logic [COORD_W-1:0] pixX,
  output logic [COORD_W-1:0] pixY,
  output logic [COLOR_W-1:0] red,
  output logic [COLOR_W-1:0] green,
  output logic [COLOR_W-1:0] blue
);

  localparam int H_TOTAL = H_VIS + H_FP + H_SYNC + H_BP;
  localparam int V_TOTAL = V_VIS + V_FP + V_SYNC + V_BP;

  logic [COL_W-1:0] colCount;
  logic [ROW_W-1:0] rowCount;
  strobe_t          strobes;

  qxga_counter_ctrl #(
    .COL_W  (COL_W),
    .ROW_W  (ROW_W),
    .H_TOTAL(H_TOTAL),
    .V_TOTAL(V_TOTAL)
  ) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .colCount(colCount),
    .rowCount(rowCount),
    .strobes (strobes)
  );

  qxga_decode_dp #(
    .COL_W      (COL_W),
    .ROW_W      (ROW_W),
    .COORD_W    (COORD_W),
    .ROW_SHIFT  (ROW_SHIFT),
    .COLOR_W    (COLOR_W),
    .H_VIS      (H_VIS),
    .H_FP       (H_FP),
    .H_SYNC     (H_SYNC),
    .V_VIS      (V_VIS),
    .V_FP       (V_FP),
    .V_SYNC     (V_SYNC),
    .PAT_COL_BIT(PAT_COL_BIT),
    .PAT_ROW_BIT(PAT_ROW_BIT)
  ) u_dp (
    .clk        (clk),
    .rst        (rst),
    .colCount   (colCount),
    .rowCount   (rowCount),
    .strobes    (strobes),
    .hsyncN     (hsyncN),
    .vsyncN     (vsyncN),
    .activeVideo(activeVideo),
    .lineEnd    (lineEnd),
    .lastRow    (lastRow),
    .pixX       (pixX),
    .pixY       (pixY),
    .red        (red),
    .green      (green),
    .blue       (blue)
  );

endmodule

// File: tb/qxga_timing_gen_tb.sv
module qxga_timing_gen_tb;

  localparam int HV = 16, HF = 2, HS = 3, HB = 3;
  localparam int VV = 8,  VF = 1, VS = 2, VB = 2;
  localparam int HT = HV + HF + HS + HB;
  localparam int VT = VV + VF + VS + VB;
  localparam int PCB = 2, PRB = 1;
  localparam int CW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hsyncN, vsyncN, activeVideo, lineEnd, lastRow;
  logic [7:0] pixX, pixY;
  logic [CW-1:0] red, green, blue;

  always #4 clk = ~clk;   // 125 MHz

  qxga_timing_gen #(
    .H_VIS(HV), .H_FP(HF), .H_SYNC(HS), .H_BP(HB),
    .V_VIS(VV), .V_FP(VF), .V_SYNC(VS), .V_BP(VB),
    .PAT_COL_BIT(PCB), .PAT_ROW_BIT(PRB), .COLOR_W(CW)
  ) u_dut (
    .clk(clk), .rst(rst),
    .hsyncN(hsyncN), .vsyncN(vsyncN), .activeVideo(activeVideo),
    .lineEnd(lineEnd), .lastRow(lastRow),
    .pixX(pixX), .pixY(pixY),
    .red(red), .green(green), .blue(blue)
  );

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  bit started = 0;
  bit inReset = 1;

  // Behavioural model: position of the counters and expected outputs.
  int mCol = 0, mRow = 0;
  int eHs, eVs, eAct, eEnd, eLast, eX, eY, eRed;

  always @(posedge clk) begin
    started = 1;
    cycles++;
    if (rst) begin
      inReset = 1;
      eHs = 1; eVs = 1; eAct = 0; eEnd = 0; eLast = 0;
      eX = 0; eY = 0; eRed = 0;
      mCol = 0; mRow = 0;
    end else begin
      inReset = 0;
      eHs   = (mCol >= HV + HF && mCol < HV + HF + HS) ? 0 : 1;
      eVs   = (mRow >= VV + VF && mRow < VV + VF + VS) ? 0 : 1;
      eAct  = (mCol < HV && mRow < VV) ? 1 : 0;
      eEnd  = (mCol == HT - 1) ? 1 : 0;
      eLast = (mRow == VT - 1) ? 1 : 0;
      eX    = mCol % 256;
      eY    = (mRow / 4) % 256;
      eRed  = (eAct == 1 && ((mCol >> PCB) % 2) == 0 && ((mRow >> PRB) % 2) == 0)
              ? (1 << CW) - 1 : 0;
      mCol++;
      if (mCol == HT) begin
        mCol = 0;
        mRow++;
        if (mRow == VT) mRow = 0;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cycles, act, exp);
    end
  endtask

  // Compare every output on the falling edge.
  always @(negedge clk) begin
    if (started) begin
      string rtag;
      rtag = inReset ? "R1" : "R10";
      chk({rtag, " R4 hsyncN"}, int'(hsyncN), eHs);
      chk({rtag, " R5 vsyncN"}, int'(vsyncN), eVs);
      chk({rtag, " R7 activeVideo"}, int'(activeVideo), eAct);
      chk({rtag, " R2 lineEnd"}, int'(lineEnd), eEnd);
      chk({rtag, " R6 lastRow"}, int'(lastRow), eLast);
      chk({rtag, " R8 pixX"}, int'(pixX), eX);
      chk({rtag, " R3 R8 pixY"}, int'(pixY), eY);
      chk({rtag, " R9 red"}, int'(red), eRed);
      chk({rtag, " R9 green"}, int'(green), 0);
      chk({rtag, " R9 blue"}, int'(blue), 0);
    end
  end

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;                     // R1: first sample after release is column 0, line 0
    repeat (3 * HT * VT + 40) @(negedge clk);   // three frames, all wraps (R2, R3)
    rst = 1'b1;                     // R1: reset in the middle of a frame
    repeat (2) @(negedge clk);
    rst = 1'b0;
    repeat (HT * VT + HT * 2) @(negedge clk);
    finishRun();
  end

  initial begin
    #400000;
    mismatched++;
    compared++;
    $display("FAIL watchdog expired at cycle %0d", cycles);
    finishRun();
  end

endmodule